// File: doc/BRIEF.md
# Interleaved Block-Fill Engine

This block serves a cache miss. The cache gives it a word address and a block size of one, two or four words. The engine reads the block from four banks, each one word wide, and returns the words one at a time in ascending address order. Each word comes with a one-cycle valid pulse.

In interleaved mode, the engine sends the block address once. All banks that hold part of the block then access at the same time, and the words come back in consecutive transfer slots. In sequential mode, each word pays the address, access and transfer cost in turn. Sequential mode exists as a comparison point. When the last word of a fill is delivered, the engine reports how many cycles the fill stalled the requester.

The engine takes one fill at a time. While a fill is in progress, `busy` is high and new requests are refused. The bank contents are fixed and are loaded at reset. Writes are not supported.

Top module: `ilv_fill`

## Requirements
- R1: While reset is high, and after reset until the first accepted request, `busy`, `word_valid` and `fill_done` are low.
- R2: Word address A sits in bank A mod 4, at row A div 4. After reset it holds `(A * 32'h00010003) ^ 32'h5A000000`, truncated to 32 bits. `word_data` carries that value for the word being delivered.
- R3: An interleaved fill of N words lasts 28 + 4N cycles. This gives 32 cycles for one word, 36 for two and 44 for four.
- R4: In interleaved mode, word k of the block (k counted from 0) has `word_valid` high in cycle 31 + 4k. Cycle 0 is the cycle that follows the accepting clock edge. Words come out in ascending address order, and each valid lasts one cycle.
- R5: In sequential mode (`interleave` low), word k is delivered in cycle 32(k+1) − 1, and a fill of N words lasts 32N cycles.
- R6: The size code selects the block size: 0 gives one word, 1 gives two words, and 2 or 3 give four words.
- R7: The address bits below the block size are ignored. The block starts at the aligned address.
- R8: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` is then high from cycle 0 through the cycle of the last word, and it is low afterwards. A request made while `busy` is high is dropped and produces no words.
- R9: Fills do not overlap. A fill that begins right after another fill of the same block, which hits the same banks, still takes its full length.
- R10: `fill_done` is high only together with the last word's `word_valid`. In that cycle, `fill_cycles` equals the fill's total length in cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fill request |
| req_addr | input | 6 | Word address of the block |
| req_size | input | 2 | Size code (0: 1 word, 1: 2 words, 2/3: 4 words) |
| interleave | input | 1 | 1: overlapped bank access; 0: sequential per word |
| busy | output | 1 | Fill in progress; requests refused |
| word_valid | output | 1 | One-cycle pulse per delivered word |
| word_data | output | 32 | Delivered word |
| fill_done | output | 1 | High with the last word of a fill |
| fill_cycles | output | 8 | Total fill length, valid with `fill_done` |

## Verification
Each result is due at a fixed cycle offset from the accepting edge. In interleaved mode, word k is due at cycle 31 + 4k. In sequential mode, it is due at cycle 32k + 31. The done flag and the cycle total come with the last word. The driver records the accepting cycle and queues each expected word with its due cycle. The monitor samples on the falling edge and compares the data, the cycle of arrival and the done/total values against the head of the queue. Any word that arrives early or late, or any word that no request asked for, counts as a failure.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int NUM_BANKS = 4;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WAIT,
        PH_XFER
    } fill_phase_e;

    // size code -> number of words in the block
    function automatic int unsigned block_words(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 4;
        endcase
    endfunction

    // content loaded into each bank location at reset
    function automatic logic [31:0] seed_word(input int unsigned waddr);
        return (32'(waddr) * 32'h0001_0003) ^ 32'h5A00_0000;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
    import ilv_pkg::*;
#(
    parameter int ROW_W   = 4,
    parameter int DATA_W  = 32,
    parameter int BANK_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ROW_W-1:0]  row,
    output logic [DATA_W-1:0] dout
);
    localparam int ROWS = 1 << ROW_W;

    logic [DATA_W-1:0] cells [ROWS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++)
                cells[r] <= DATA_W'(seed_word(r * NUM_BANKS + BANK_ID));
            dout <= '0;
        end else if (rd_en) begin
            dout <= cells[row];
        end
    end
endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
    import ilv_pkg::*;
#(
    parameter int T_ADDR = 4,
    parameter int T_ACC  = 24,
    parameter int T_XFER = 4,
    parameter int CYC_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             ilv_mode,
    input  logic [1:0]       last_idx,
    output fill_phase_e      phase,
    output logic [1:0]       widx,
    output logic             rd_fire,
    output logic             word_fire,
    output logic             last_fire,
    output logic [CYC_W-1:0] run_cnt
);
    localparam int T_MAX = (T_ACC > T_ADDR) ? ((T_ACC > T_XFER) ? T_ACC : T_XFER)
                                            : ((T_ADDR > T_XFER) ? T_ADDR : T_XFER);
    localparam int PH_W  = $clog2(T_MAX + 1);

    logic [PH_W-1:0] ph_cnt;
    logic [PH_W-1:0] ph_end;

    always_comb begin
        case (phase)
            PH_ADDR: ph_end = PH_W'(T_ADDR - 1);
            PH_WAIT: ph_end = PH_W'(T_ACC - 1);
            default: ph_end = PH_W'(T_XFER - 1);
        endcase
    end

    assign rd_fire   = (phase == PH_WAIT) && (ph_cnt == ph_end);
    assign word_fire = (phase == PH_XFER) && (ph_cnt == ph_end);
    assign last_fire = word_fire && (widx == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            ph_cnt  <= '0;
            widx    <= '0;
            run_cnt <= '0;
        end else if (phase == PH_IDLE) begin
            if (start) begin
                phase   <= PH_ADDR;
                ph_cnt  <= '0;
                widx    <= '0;
                run_cnt <= '0;
            end
        end else begin
            run_cnt <= run_cnt + 1'b1;
            if (ph_cnt != ph_end) begin
                ph_cnt <= ph_cnt + 1'b1;
            end else begin
                ph_cnt <= '0;
                case (phase)
                    PH_ADDR: phase <= PH_WAIT;
                    PH_WAIT: phase <= PH_XFER;
                    default: begin
                        if (widx == last_idx) begin
                            phase <= PH_IDLE;
                        end else begin
                            widx  <= widx + 1'b1;
                            phase <= ilv_mode ? PH_XFER : PH_ADDR;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/ilv_fill.sv
module ilv_fill
    import ilv_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int T_ADDR = 4,
    parameter int T_ACC  = 24,
    parameter int T_XFER = 4,
    parameter int CYC_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              interleave,
    output logic              busy,
    output logic              word_valid,
    output logic [DATA_W-1:0] word_data,
    output logic              fill_done,
    output logic [CYC_W-1:0]  fill_cycles
);
    localparam int ROW_W = ADDR_W - 2;

    fill_phase_e       phase;
    logic [1:0]        widx;
    logic              rd_fire, word_fire, last_fire;
    logic [CYC_W-1:0]  run_cnt;
    logic              start;

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        last_q;
    logic              ilv_q;
    logic [1:0]        cur_bank;

    logic [NUM_BANKS-1:0] bank_rd;
    logic [DATA_W-1:0]    bank_dout [NUM_BANKS];

    assign busy     = (phase != PH_IDLE);
    assign start    = req_valid && !busy;
    assign cur_bank = base_q[1:0] + widx;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            last_q <= '0;
            ilv_q  <= 1'b0;
        end else if (start) begin
            base_q <= req_addr & ~ADDR_W'(block_words(req_size) - 1);
            last_q <= 2'(block_words(req_size) - 1);
            ilv_q  <= interleave;
        end
    end

    ilv_seq #(
        .T_ADDR(T_ADDR), .T_ACC(T_ACC), .T_XFER(T_XFER), .CYC_W(CYC_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .ilv_mode (ilv_q),
        .last_idx (last_q),
        .phase    (phase),
        .widx     (widx),
        .rd_fire  (rd_fire),
        .word_fire(word_fire),
        .last_fire(last_fire),
        .run_cnt  (run_cnt)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [1:0] offs;
        assign offs = 2'(b) - base_q[1:0];
        // interleaved: every bank of the block reads together; sequential: only the current word's bank
        assign bank_rd[b] = rd_fire && (ilv_q ? (offs <= last_q) : (2'(b) == cur_bank));

        ilv_bank #(
            .ROW_W(ROW_W), .DATA_W(DATA_W), .BANK_ID(b)
        ) u_bank (
            .clk  (clk),
            .rst  (rst),
            .rd_en(bank_rd[b]),
            .row  (base_q[ADDR_W-1:2]),
            .dout (bank_dout[b])
        );
    end

    assign word_valid  = word_fire;
    assign word_data   = bank_dout[cur_bank];
    assign fill_done   = last_fire;
    assign fill_cycles = last_fire ? (run_cnt + 1'b1) : '0;
endmodule

// File: rtl/ilv_fill_chk.sv
module ilv_fill_chk #(
    parameter int CYC_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             busy,
    input logic             word_valid,
    input logic             fill_done,
    input logic [CYC_W-1:0] fill_cycles
);
    p_valid_in_fill_r8: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> busy);

    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> !busy);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !fill_done) |=> busy);

    p_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    p_done_with_word_r10: assert property (@(posedge clk) disable iff (rst)
        fill_done |-> (word_valid && fill_cycles != '0));
endmodule

bind ilv_fill ilv_fill_chk #(.CYC_W(CYC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .busy       (busy),
    .word_valid (word_valid),
    .fill_done  (fill_done),
    .fill_cycles(fill_cycles)
);

// File: tb/ilv_fill_bench.sv
module ilv_fill_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        interleave = 1'b1;
    logic        busy, word_valid, fill_done;
    logic [31:0] word_data;
    logic [7:0]  fill_cycles;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] data;
        int          due;
        bit          last;
        int          total;
        string       tag;
    } exp_t;

    exp_t sb[$];

    ilv_fill u_ilv_fill (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .interleave(interleave), .busy(busy),
        .word_valid(word_valid), .word_data(word_data), .fill_done(fill_done),
        .fill_cycles(fill_cycles)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] model_word(input int a);
        return (32'(a) * 32'h0001_0003) ^ 32'h5A00_0000;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // driver: issue one fill and queue its expected words
    task automatic issue(input int addr, input int code, input bit ilv, input string tag);
        int n, base, acc, total;
        while (busy) @(negedge clk);
        req_valid  = 1'b1;
        req_addr   = 6'(addr);
        req_size   = 2'(code);
        interleave = ilv;
        @(posedge clk);
        @(negedge clk);
        acc = cyc;
        req_valid = 1'b0;
        n = (code == 0) ? 1 : (code == 1) ? 2 : 4;
        base = addr & ~(n - 1);
        total = ilv ? (28 + 4 * n) : (32 * n);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.data  = model_word(base + k);
            e.due   = acc + (ilv ? (31 + 4 * k) : (32 * (k + 1) - 1));
            e.last  = (k == n - 1);
            e.total = total;
            e.tag   = tag;
            sb.push_back(e);
        end
    endtask

    task automatic drain();
        while (sb.size() != 0 || busy) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && word_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8", "unrequested word", word_data, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(word_data == e.data, "R2", {e.tag, " data"}, word_data, e.data);
                check(cyc == e.due, e.tag, "arrival cycle", cyc, e.due);
                check(fill_done == e.last, "R10", {e.tag, " done flag"}, fill_done, e.last);
                if (e.last)
                    check(fill_cycles == 8'(e.total), "R10", {e.tag, " fill_cycles"},
                          fill_cycles, e.total);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({busy, word_valid, fill_done} == 3'b000, "R1", "outputs in reset",
              {busy, word_valid, fill_done}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check({busy, word_valid, fill_done} == 3'b000, "R1", "outputs after reset",
              {busy, word_valid, fill_done}, 0);

        // interleaved sizes: R3, R4, R6
        issue(8, 0, 1'b1, "R3_one");
        issue(18, 1, 1'b1, "R4_two");
        issue(36, 2, 1'b1, "R4_four");
        issue(52, 3, 1'b1, "R6_code3");
        drain();

        // misaligned addresses: R7
        issue(13, 2, 1'b1, "R7_four");
        issue(7, 1, 1'b1, "R7_two");
        drain();

        // sequential mode: R5
        issue(3, 0, 1'b0, "R5_one");
        issue(42, 1, 1'b0, "R5_two");
        issue(60, 2, 1'b0, "R5_four");
        drain();

        // back-to-back fills on the same banks: R9
        issue(20, 2, 1'b1, "R9_first");
        issue(20, 2, 1'b1, "R9_second");
        drain();

        // request while busy is dropped: R8
        issue(28, 1, 1'b1, "R8_fill");
        repeat (5) @(negedge clk);
        check(busy == 1'b1, "R8", "busy during fill", busy, 1);
        req_valid = 1'b1; req_addr = 6'd44; req_size = 2'd2;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        drain();
        repeat (60) @(negedge clk);
        check(busy == 1'b0, "R8", "no fill from dropped request", busy, 0);
        check(sb.size() == 0, "R8", "scoreboard empty", sb.size(), 0);

        finish_run();
    end
endmodule